// File: doc/BRIEF.md
# Bus-Mapped BCD Calendar Clock

This block is a calendar clock that occupies the eight highest byte addresses of a 15-bit, byte-wide, SRAM-style bus. A set of free-running counters holds seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year, all in packed BCD. The counters advance on every pulse of a 1 Hz tick input. A second set of registers, the view bank, is what the host actually reads. The view bank is reloaded from the counters as a whole, in one clock cycle, right after each advance.

The host reaches the block with the usual chip-select, output-enable and write-enable strobes, sampled on the system clock. Byte 0x7FF8 is a control byte. Its bit 6 is a freeze bit: while it is 1, the view bank keeps the time captured at the last load and the counters keep running. Its low six bits are plain storage. Writing a time byte sets both the counter and its view register. Any access below 0x7FF8 is handed to an external memory through a separate select output, and the block keeps its data output off for such an access.

Top module: `rtc_bus_clock`

## Requirements
- R1: After reset the view bank and the counters hold 00:00:00, day of week 01, day of month 01, month 01, year 00, and the control byte reads 0x00.
- R2: Each tick adds one second in BCD. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into the day-of-week and day-of-month fields.
- R3: Day of week counts 01 to 07 and wraps from 07 to 01 on a day carry.
- R4: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 in month 02. When the year is divisible by 4 (00 counts), month 02 instead wraps after 29. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: One clock cycle after the cycle in which the tick is high, every field of the view bank holds the advanced count, all loaded in the same cycle.
- R6: While control bit 6 is 1, the view bank does not change, except for a byte the host writes. The counters keep advancing. After the bit is written back to 0, the next tick loads the current count.
- R7: A write that sets control bit 6 in the same cycle as a view-bank load does not cancel that load.
- R8: Control bits 5:0 read back as written and do not affect counting. Bit 7 always reads 0.
- R9: Byte map: 0x7FF9 seconds, 0x7FFA minutes, 0x7FFB hours, 0x7FFC day of month, 0x7FFD month, 0x7FFE year, 0x7FFF day of week. A host write to one of these bytes loads that counter and its view register at the same clock edge.
- R10: The data output is enabled only when chip select and output enable are low, write enable is high and the address lies in 0x7FF8 to 0x7FFF.
- R11: For an address below 0x7FF8, the external memory select follows chip select, the block keeps its data output off, and a write changes none of its registers. For an address in the window, the external select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data from host |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_rdata | output | 8 | Read data for the clock window |
| bus_rdata_oe | output | 1 | High while the block drives read data |
| mem_cs_n | output | 1 | Select for the external memory below the window |

## Verification
The case hardest to reach from the ports is a freeze request that lands exactly in the one cycle in which the view bank is reloaded. The host write of the control byte has to reach the clock edge one cycle after the tick. The bench produces this with a directed sequence: it raises the tick, then drops the tick and starts the control write on the next falling edge. It then reads back the freshly advanced seconds. Calendar carries (leap and common February, 30-day months, year 99) are reached by writing the time bytes just short of the rollover. Random ticks, freeze toggles and seconds writes, drawn from a fixed seed, are checked against a binary reference calendar in the bench.

// File: rtl/rtc_bus_pkg.sv
// Shared types and BCD helpers for the bus-mapped calendar clock.
// Assumes all fields are packed two-digit BCD; invalid digits are not repaired.
package rtc_bus_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 8'h01, mday: 8'h01,
                                       wday: 8'h01, hours: 8'h00, mins: 8'h00,
                                       secs: 8'h00};

    // Byte index within the eight-byte window (low three address bits)
    localparam logic [2:0] FLD_CTRL = 3'd0;
    localparam logic [2:0] FLD_SEC  = 3'd1;
    localparam logic [2:0] FLD_MIN  = 3'd2;
    localparam logic [2:0] FLD_HOUR = 3'd3;
    localparam logic [2:0] FLD_MDAY = 3'd4;
    localparam logic [2:0] FLD_MON  = 3'd5;
    localparam logic [2:0] FLD_YEAR = 3'd6;
    localparam logic [2:0] FLD_WDAY = 3'd7;

    // Add one to a BCD byte (no wrap handling beyond the digit carry)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four
    function automatic logic bcd_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last day of a month, in BCD
    function automatic logic [7:0] bcd_month_len(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Select one time byte by window index (control index returns zero)
    function automatic logic [7:0] field_get(input rtc_time_t t, input logic [2:0] idx);
        case (idx)
            FLD_SEC:  return t.secs;
            FLD_MIN:  return t.mins;
            FLD_HOUR: return t.hours;
            FLD_MDAY: return t.mday;
            FLD_MON:  return t.mon;
            FLD_YEAR: return t.year;
            FLD_WDAY: return t.wday;
            default:  return 8'h00;
        endcase
    endfunction

    // Replace one time byte by window index (control index leaves t unchanged)
    function automatic rtc_time_t field_put(input rtc_time_t t, input logic [2:0] idx,
                                            input logic [7:0] v);
        rtc_time_t r;
        r = t;
        case (idx)
            FLD_SEC:  r.secs  = v;
            FLD_MIN:  r.mins  = v;
            FLD_HOUR: r.hours = v;
            FLD_MDAY: r.mday  = v;
            FLD_MON:  r.mon   = v;
            FLD_YEAR: r.year  = v;
            FLD_WDAY: r.wday  = v;
            default:  r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_count_chain.sv
// Free-running BCD calendar counters. Advances one second per tick and
// carries through minutes, hours, weekday, day of month, month and year.
// Assumes the host writes only valid BCD; a host write wins over the advance
// for the byte it targets.
module rtc_count_chain
    import rtc_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output rtc_time_t  cnt
);

    rtc_time_t nxt;
    logic      c_sec, c_min, c_hour, c_mday, c_mon;

    // Carry chain and next count
    always_comb begin
        nxt    = cnt;
        c_sec  = tick   && (cnt.secs  == 8'h59);
        c_min  = c_sec  && (cnt.mins  == 8'h59);
        c_hour = c_min  && (cnt.hours == 8'h23);
        c_mday = c_hour && (cnt.mday  == bcd_month_len(cnt.mon, cnt.year));
        c_mon  = c_mday && (cnt.mon   == 8'h12);
        if (tick)   nxt.secs  = c_sec  ? 8'h00 : bcd_inc(cnt.secs);
        if (c_sec)  nxt.mins  = c_min  ? 8'h00 : bcd_inc(cnt.mins);
        if (c_min)  nxt.hours = c_hour ? 8'h00 : bcd_inc(cnt.hours);
        if (c_hour) nxt.wday  = (cnt.wday == 8'h07) ? 8'h01 : bcd_inc(cnt.wday);
        if (c_hour) nxt.mday  = c_mday ? 8'h01 : bcd_inc(cnt.mday);
        if (c_mday) nxt.mon   = c_mon  ? 8'h01 : bcd_inc(cnt.mon);
        if (c_mon)  nxt.year  = (cnt.year == 8'h99) ? 8'h00 : bcd_inc(cnt.year);
        if (wr_en)  nxt       = field_put(nxt, wr_idx, wr_data);
    end

    // Counter state register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= TIME_RST;
        else        cnt <= nxt;
    end

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt.secs <= 8'h59) && (cnt.secs[3:0] <= 4'd9)); // R2
    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt.wday >= 8'h01) && (cnt.wday <= 8'h07)); // R3
    AST_MDAY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt.mday >= 8'h01) && (cnt.mday <= bcd_month_len(cnt.mon, cnt.year))); // R4

endmodule

// File: rtl/rtc_view_bank.sv
// Host-visible snapshot of the counters plus the control byte. Loads all
// time bytes one cycle after each tick unless the freeze bit is set.
// Assumes tick pulses are at least two cycles apart.
module rtc_view_bank
    import rtc_bus_pkg::*;
#(
    parameter int CAL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  rtc_time_t        cnt,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [7:0]       wr_data,
    output rtc_time_t        view,
    output logic             halt,
    output logic [CAL_W-1:0] cal
);

    localparam int HALT_BIT = CAL_W;

    logic      load_due;
    rtc_time_t view_nxt;

    // Snapshot selection: counter load, then host byte override
    always_comb begin
        view_nxt = view;
        if (load_due && !halt) view_nxt = cnt;
        if (wr_en)             view_nxt = field_put(view_nxt, wr_idx, wr_data);
    end

    // Load-pending flag, snapshot and control byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_due <= 1'b0;
            view     <= TIME_RST;
            halt     <= 1'b0;
            cal      <= '0;
        end else begin
            load_due <= tick;
            view     <= view_nxt;
            if (wr_en && (wr_idx == FLD_CTRL)) begin
                halt <= wr_data[HALT_BIT];
                cal  <= wr_data[CAL_W-1:0];
            end
        end
    end

    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_due && !halt && !wr_en) |=> (view == $past(cnt))); // R5
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> (view == $past(view))); // R6

endmodule

// File: rtl/rtc_bus_clock.sv
// Top level: decodes the eight-byte window at the top of the address space,
// routes host writes to counters and view bank, and muxes read data.
// Assumes strobes are synchronous to clk; accesses below the window belong
// to an external memory selected through mem_cs_n.
module rtc_bus_clock
    import rtc_bus_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int CAL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    output logic [7:0]        bus_rdata,
    output logic              bus_rdata_oe,
    output logic              mem_cs_n
);

    localparam int IDX_W = 3;
    localparam int PAD_W = 8 - CAL_W - 1;

    rtc_time_t        cnt, view;
    logic             halt;
    logic [CAL_W-1:0] cal;
    logic             in_win, wr_en;
    logic [IDX_W-1:0] idx;

    // Window decode and strobe qualification
    always_comb begin
        in_win       = &bus_addr[ADDR_W-1:IDX_W];
        idx          = bus_addr[IDX_W-1:0];
        wr_en        = !bus_cs_n && !bus_we_n && in_win;
        bus_rdata_oe = !bus_cs_n && !bus_oe_n && bus_we_n && in_win;
        mem_cs_n     = bus_cs_n || in_win;
    end

    // Read data mux
    always_comb begin
        if (idx == FLD_CTRL) bus_rdata = {{PAD_W{1'b0}}, halt, cal};
        else                 bus_rdata = field_get(view, idx);
    end

    rtc_count_chain i_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .cnt     (cnt)
    );

    rtc_view_bank #(.CAL_W(CAL_W)) i_view (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .cnt     (cnt),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .view    (view),
        .halt    (halt),
        .cal     (cal)
    );

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !bus_rdata_oe); // R11
    AST_RD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> (mem_cs_n && !bus_oe_n)); // R10

endmodule

// File: tb/test_rtc_bus_clock.sv
module test_rtc_bus_clock;

    localparam logic [14:0] BASE = 15'h7FF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_cs_n = 1'b1;
    logic        bus_oe_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic        mem_cs_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ec [8];
    logic [7:0] ev [8];
    logic       eh;
    logic [5:0] ecal;

    always #5 clk = ~clk;

    rtc_bus_clock i_rtc_bus_clock (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .mem_cs_n(mem_cs_n)
    );

    function automatic int bin(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Reference calendar advance (binary arithmetic)
    task automatic ref_tick();
        int s, m, h, d, mo, y, w;
        s = bin(ec[1]); m = bin(ec[2]); h = bin(ec[3]); d = bin(ec[4]);
        mo = bin(ec[5]); y = bin(ec[6]); w = bin(ec[7]);
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin
                    h = 0; w = w % 7 + 1; d++;
                    if (d > mdays(mo, y)) begin
                        d = 1; mo++;
                        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
                    end
                end
            end
        end
        ec[1] = bcd(s); ec[2] = bcd(m); ec[3] = bcd(h); ec[4] = bcd(d);
        ec[5] = bcd(mo); ec[6] = bcd(y); ec[7] = bcd(w);
        if (!eh) for (int i = 1; i < 8; i++) ev[i] = ec[i];
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        @(negedge clk);
        ref_tick();
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1; bus_we_n = 1'b1;
    endtask

    task automatic set_field(input int idx, input logic [7:0] v);
        bus_write(BASE + 15'(idx), v);
        ec[idx] = v; ev[idx] = v;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        bus_write(BASE, v);
        eh = v[6]; ecal = v[5:0];
    endtask

    task automatic rd(input int idx, output logic [7:0] d, output logic oe);
        @(negedge clk);
        bus_addr = BASE + 15'(idx); bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b1;
        #1;
        d = bus_rdata; oe = bus_rdata_oe;
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    task automatic chk_field(input string req, input int idx);
        logic [7:0] d; logic oe;
        rd(idx, d, oe);
        chk(req, d, ev[idx]);
        chk({req, " oe"}, {7'd0, oe}, 8'd1);
    endtask

    task automatic chk_all(input string req);
        for (int i = 1; i < 8; i++) chk_field(req, i);
    endtask

    task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                            input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] w);
        set_field(4, 8'h01);
        set_field(6, y); set_field(5, mo); set_field(4, d);
        set_field(3, h); set_field(2, m); set_field(1, s); set_field(7, w);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin ec[i] = 8'h00; ev[i] = 8'h00; end
        ec[4] = 8'h01; ec[5] = 8'h01; ec[7] = 8'h01;
        ev[4] = 8'h01; ev[5] = 8'h01; ev[7] = 8'h01;
        eh = 1'b0; ecal = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_all("R1");
        rd(0, d, oe); chk("R1 ctrl", d, 8'h00);

        // R5: plain tick, all fields loaded
        do_tick(); chk_all("R5");

        // R2 R3 R4: full rollover at end of year 99
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h07);
        chk_all("R9 write-through");
        do_tick(); chk_all("R2 R3 R4 year wrap");

        // R4: leap February
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h03);
        do_tick(); chk_field("R4 leap 29", 4);
        set_field(3, 8'h23); set_field(2, 8'h59); set_field(1, 8'h59);
        do_tick(); chk_field("R4 leap end", 4); chk_field("R4 leap month", 5);
        // R4: common February and year 00
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h05);
        do_tick(); chk_field("R4 common", 4); chk_field("R4 common month", 5);
        set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h05);
        do_tick(); chk_field("R4 year00", 4);
        set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h06);
        do_tick(); chk_all("R4 thirty");

        // R8: calibration bits stored, bit 7 dropped, no effect on counting
        set_ctrl(8'hBF);
        rd(0, d, oe); chk("R8 ctrl", d, 8'h3F);
        do_tick(); chk_field("R8 count", 1);
        set_ctrl(8'h00);

        // R6: freeze holds view while counters run, refresh after clear
        set_ctrl(8'h40);
        repeat (3) do_tick();
        chk_all("R6 frozen");
        set_ctrl(8'h00);
        chk_field("R6 still old", 1);
        do_tick(); chk_all("R6 refresh");

        // R7: freeze written in the load cycle
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) begin
            tick_1hz = 1'b0;
            bus_addr = BASE; bus_wdata = 8'h40; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        end
        @(negedge clk) begin bus_cs_n = 1'b1; bus_we_n = 1'b1; end
        ref_tick(); eh = 1'b1; ecal = '0;
        chk_all("R7 load kept");
        do_tick(); chk_field("R7 then frozen", 1);
        set_ctrl(8'h00);

        // R10: strobe gating
        @(negedge clk);
        bus_addr = BASE + 15'd1; bus_cs_n = 1'b0; bus_oe_n = 1'b1; #1;
        chk("R10 oe high", {7'd0, bus_rdata_oe}, 8'd0);
        bus_cs_n = 1'b1; bus_oe_n = 1'b0; #1;
        chk("R10 cs high", {7'd0, bus_rdata_oe}, 8'd0);
        bus_oe_n = 1'b1;

        // R11: below-window access
        @(negedge clk);
        bus_addr = 15'h1234; bus_cs_n = 1'b0; bus_oe_n = 1'b0; #1;
        chk("R11 mem sel", {7'd0, mem_cs_n}, 8'd0);
        chk("R11 no drive", {7'd0, bus_rdata_oe}, 8'd0);
        bus_addr = BASE + 15'd2; #1;
        chk("R11 win sel", {7'd0, mem_cs_n}, 8'd1);
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;
        bus_write(15'h7FF1, 8'h42);
        bus_write(15'h7FF0, 8'h40);
        chk_all("R11 untouched");
        rd(0, d, oe); chk("R11 ctrl", d, 8'h00);

        // Random mix: ticks, freeze toggles, seconds writes
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 6) do_tick();
            else if (op < 8) set_ctrl(eh ? 8'h00 : 8'h40);
            else set_field(1, bcd(int'($urandom_range(50, 59))));
            if (it % 8 == 7) chk_all("R5 R6 random");
        end
        set_ctrl(8'h00);
        do_tick(); chk_all("R2 R6 final");

        done = 1'b1;
        finish_run();
    end

endmodule